// File: doc/BRIEF.md
# Twelve-Line GPIO Controller with Latched Level Interrupts

This block is a general-purpose I/O controller for twelve lines, attached to a simple 32-bit register bus with a 5-bit byte address. Software drives the lines through an output value register and an output-enable register. It reads back the pad levels through an input register fed by two-flop synchronisers. A 32-bit register that selects pin functions is stored and presented on an output vector for the pad ring.

Every line can also raise an interrupt on a level. The polarity for each line is chosen by one bit in every four-bit nibble of two type registers: the low register covers lines 0 to 7 and the high register covers lines 8 to 11. A line at its active level sets its bit in the status register, whether or not the line is enabled. Writing a one to a status bit acknowledges it. Because the source is a level, a bit whose line is still active sets again on the next cycle. The single interrupt output is the OR of the status bits that the enable register unmasks.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset, all eight registers read zero, `irq_o` is 0, `pad_oe_o` and `pad_out_o` are 0 and `mux_sel_o` is 0. Every line therefore starts as an input, masked, with active-high polarity.
- R2: The register offsets are: output value 0x00, output enable 0x04, input 0x08, status 0x0C, low type 0x10, enable 0x14, high type 0x18, mux 0x1C. The output value, output enable and enable registers hold bits 11:0, and bits 31:12 of these registers read zero. Both type registers and the mux register store all 32 bits.
- R3: `pad_oe_o` equals the output-enable register. Bit n of `pad_out_o` is bit n of the output value register when output-enable bit n is 1, and 0 otherwise.
- R4: Each `pad_in_i` bit passes through two flops. A level applied before clock edge k reads back at offset 0x08 after edge k+1. Writes to 0x08 have no effect.
- R5: The polarity of line n is bit 4*n of the low type register for n < 8, and bit 4*(n-8) of the high type register for n >= 8. A 0 selects active-high and a 1 selects active-low. All other type bits have no effect on interrupts.
- R6: A line at its active level sets its status bit (offset 0x0C, bit n). A pad change before edge k shows in status after edge k+2, independent of the enable register.
- R7: Writing 1 to a status bit clears it if its line is inactive. Writing 0 leaves the bit unchanged.
- R8: When an acknowledge and an active level coincide in the same cycle, the status bit stays set.
- R9: `irq_o` is 1 exactly when some bit is set in both the status register and the enable register.
- R10: `mux_sel_o` always equals the mux register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not reading |
| pad_in_i | input | 12 | Asynchronous pad levels |
| pad_out_o | output | 12 | Pad output values, gated by output enable |
| pad_oe_o | output | 12 | Pad output enables |
| mux_sel_o | output | 32 | Stored pin-function selection |
| irq_o | output | 1 | Combined unmasked interrupt |

## Verification
The register table writes all-ones and mixed patterns to every offset. This separates the 12-bit registers from the 32-bit ones and shows that the input and status offsets ignore plain writes. Pad patterns with scattered high bits are checked at the exact cycle they reach the input register and the status register, which exposes a missing or extra synchroniser stage. The polarity tests set only the selecting nibble bit, plus a neighbouring bit, for lines 3, 10 and 11; this separates the correct bit position from a wrong one and from a bit that should be ignored. The acknowledge tests cover a line that is still active, a line that has gone inactive, and an all-zero write. The enable tests use an enable pattern that misses every pending bit and one that hits a single pending bit.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned LINES_PER_TYPE = 8;

  localparam logic [ADDR_W-1:0] OFS_OUT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_OE   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_IN   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_TLO  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_EN   = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_THI  = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_MUX  = 5'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N-1:0]      sync_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      out_o,
  output logic [N-1:0]      oe_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      ack_o,
  output logic [DATA_W-1:0] mux_o
);
  logic [N-1:0]      out_q, oe_q, en_q;
  logic [DATA_W-1:0] tlo_q, thi_q, mux_q;
  logic              wr_en, rd_en;

  assign wr_en = bus_sel_i & bus_wr_i;
  assign rd_en = bus_sel_i & ~bus_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= '0;
      en_q  <= '0;
      tlo_q <= '0;
      thi_q <= '0;
      mux_q <= '0;
    end else if (wr_en) begin
      case (bus_addr_i)
        OFS_OUT: out_q <= bus_wdata_i[N-1:0];
        OFS_OE:  oe_q  <= bus_wdata_i[N-1:0];
        OFS_EN:  en_q  <= bus_wdata_i[N-1:0];
        OFS_TLO: tlo_q <= bus_wdata_i;
        OFS_THI: thi_q <= bus_wdata_i;
        OFS_MUX: mux_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  // one acknowledge pulse per written 1 at the status offset
  assign ack_o = (wr_en && bus_addr_i == OFS_STAT) ? bus_wdata_i[N-1:0] : '0;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      case (bus_addr_i)
        OFS_OUT:  bus_rdata_o[N-1:0] = out_q;
        OFS_OE:   bus_rdata_o[N-1:0] = oe_q;
        OFS_IN:   bus_rdata_o[N-1:0] = sync_i;
        OFS_STAT: bus_rdata_o[N-1:0] = status_i;
        OFS_TLO:  bus_rdata_o        = tlo_q;
        OFS_EN:   bus_rdata_o[N-1:0] = en_q;
        OFS_THI:  bus_rdata_o        = thi_q;
        OFS_MUX:  bus_rdata_o        = mux_q;
        default:  bus_rdata_o        = '0;
      endcase
    end
  end

  // polarity bit sits at the bottom of each line's nibble
  for (genvar g = 0; g < N; g++) begin : g_pol
    if (g < LINES_PER_TYPE) begin : g_lo
      assign pol_o[g] = tlo_q[NIB_W*g];
    end else begin : g_hi
      assign pol_o[g] = thi_q[NIB_W*(g-LINES_PER_TYPE)];
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;
  assign en_o  = en_q;
  assign mux_o = mux_q;
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] hit, status_q;

  // pol 0: active-high, pol 1: active-low
  assign hit = level_i ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= hit | (status_q & ~ack_i);
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en_i);

  a_r7_hold_unacked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~$past(ack_i) & ~status_q) == '0));

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit) & ~status_q) == '0));

  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N-1:0]      pad_in_i,
  output logic [N-1:0]      pad_out_o,
  output logic [N-1:0]      pad_oe_o,
  output logic [DATA_W-1:0] mux_sel_o,
  output logic              irq_o
);
  logic [N-1:0] sync_w, status_w, out_w, oe_w, en_w, pol_w, ack_w;

  gpio_sync #(.W(N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (sync_w)
  );

  gpio_regs #(.N(N)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .sync_i      (sync_w),
    .status_i    (status_w),
    .out_o       (out_w),
    .oe_o        (oe_w),
    .en_o        (en_w),
    .pol_o       (pol_w),
    .ack_o       (ack_w),
    .mux_o       (mux_sel_o)
  );

  gpio_irq_latch #(.N(N)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (sync_w),
    .pol_i    (pol_w),
    .ack_i    (ack_w),
    .en_i     (en_w),
    .status_o (status_w),
    .irq_o    (irq_o)
  );

  assign pad_out_o = out_w & oe_w;
  assign pad_oe_o  = oe_w;

  a_r3_pad_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);

  a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((status_w & en_w) != '0));
endmodule

// File: tb/sim_gpio_lvl_irq.sv
`timescale 1ns/1ps
module sim_gpio_lvl_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [11:0] pad_in = '0, pad_out, pad_oe;
  logic [31:0] mux_sel;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_lvl_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .mux_sel_o(mux_sel), .irq_o(irq)
  );

  // {addr, write data, expected read}
  localparam logic [68:0] VEC [8] = '{
    {5'h00, 32'hA5A5_5A5A, 32'h0000_0A5A},
    {5'h04, 32'hFFFF_F0F0, 32'h0000_00F0},
    {5'h10, 32'hEEEE_EEEE, 32'hEEEE_EEEE},
    {5'h18, 32'hABCD_0000, 32'hABCD_0000},
    {5'h1C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h14, 32'hFFFF_F00F, 32'h0000_000F},
    {5'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h0C, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #0.5 d = rdata;
    sel = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd_reg(5'(i*4), r);
      check("R1 reset register", r, 32'h0);
    end
    check("R1 irq_o", {31'h0, irq}, 32'h0);
    check("R1 pad_oe_o", {20'h0, pad_oe}, 32'h0);
    check("R1 mux_sel_o", mux_sel, 32'h0);

    // R2 register table walk
    for (int i = 0; i < 8; i++) begin
      wr_reg(VEC[i][68:64], VEC[i][63:32]);
      rd_reg(VEC[i][68:64], r);
      check("R2 readback", r, VEC[i][31:0]);
    end
    check("R3 pad_out gated", {20'h0, pad_out}, 32'h050);
    check("R3 pad_oe", {20'h0, pad_oe}, 32'h0F0);
    check("R10 mux_sel_o", mux_sel, 32'hDEAD_BEEF);
    check("R9 no pending irq", {31'h0, irq}, 32'h0);
    wr_reg(5'h00, 0); wr_reg(5'h04, 0); wr_reg(5'h10, 0);
    wr_reg(5'h18, 0); wr_reg(5'h14, 0);

    // R4 synchroniser latency, R6 status latency
    pad_in = 12'h3C5;
    tick(); rd_reg(5'h08, r); check("R4 input after 1 edge", r, 32'h0);
    tick(); rd_reg(5'h08, r); check("R4 input after 2 edges", r, 32'h3C5);
    rd_reg(5'h0C, r); check("R6 status not yet", r, 32'h0);
    tick(); rd_reg(5'h0C, r); check("R6 status latched", r, 32'h3C5);
    check("R9 masked irq", {31'h0, irq}, 32'h0);

    // R9 enable masking
    wr_reg(5'h14, 32'h002); check("R9 enable misses", {31'h0, irq}, 32'h0);
    wr_reg(5'h14, 32'h200); check("R9 enable hits", {31'h0, irq}, 32'h1);

    // R7 zero write, R8 ack while active
    wr_reg(5'h0C, 32'h0);   rd_reg(5'h0C, r); check("R7 zero write", r, 32'h3C5);
    wr_reg(5'h0C, 32'h201); rd_reg(5'h0C, r); check("R8 ack while active", r, 32'h3C5);
    check("R8 irq still set", {31'h0, irq}, 32'h1);
    pad_in = 12'h0;
    tick(); tick(); tick();
    wr_reg(5'h0C, 32'h3C5); rd_reg(5'h0C, r); check("R7 ack clears", r, 32'h0);
    check("R9 irq dropped", {31'h0, irq}, 32'h0);

    // R5 polarity: line 3 (low reg bit 12), lines 10 and 11 (high reg bits 8, 12)
    wr_reg(5'h10, 32'h0000_1002);
    wr_reg(5'h18, 32'h0000_1100);
    tick(); rd_reg(5'h0C, r); check("R5 active-low lines", r, 32'hC08);
    wr_reg(5'h0C, 32'hC08); rd_reg(5'h0C, r); check("R8 ack active-low", r, 32'hC08);
    pad_in = 12'h008;
    tick(); tick(); tick();
    wr_reg(5'h0C, 32'h008); rd_reg(5'h0C, r);
    check("R5 line3 high is inactive", r, 32'hC00);
    wr_reg(5'h18, 32'h0);
    tick(); rd_reg(5'h0C, r); check("R5 line3 pol bit kept", r, 32'hC00);
    wr_reg(5'h0C, 32'hC00); rd_reg(5'h0C, r); check("R7 clear high lines", r, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule